// File: doc/BRIEF.md
# Passive Serial Configuration Master

This block loads a configuration bitstream into a target device over a passive serial link. A `start` pulse begins a timed pin handshake. The block pulls the active-low request output `cfgReqN` low and waits for the target to pull both its active-low status line `statusN` and its completion line `cfgDone` low. It then releases the request and waits for `statusN` to return high. After a short settling pause it accepts bitstream words from a valid/ready stream and shifts each one out on `serData`/`serClk`.

Each word goes out least significant bit first. The clock idles low and the target samples data on its rising edge. A final word that holds fewer than four bytes has its unused upper bytes forced to zero. A load whose final word is whole gets one extra all-zero word instead. The block then waits for both target lines to read high and reports `done`, or reports `error` with a cause code.

All timing windows are given in microseconds and converted through `CLK_PER_US`. The serial clock's half period is set by `CLK_HALF` so the link rate can be capped (13 cycles at 250 MHz keeps it below 10 MHz). `statusN` and `cfgDone` pass through `SYNC_STAGES` flip-flops before the control logic sees them.

Top module: `pserial_cfg_master`

## Requirements
- R1: While reset is held and after it is released, `cfgReqN` is 1, `serClk` and `serData` are 0, and `busy`, `done`, `error` and `inReady` are 0.
- R2: A `start` pulse raises `busy` and drives `cfgReqN` low. If `statusN` and `cfgDone` are not both seen low within ACK_US µs, the block raises `error`, releases `cfgReqN` and returns to idle. The cause code is then {0, cfgDone stayed high, statusN stayed high}: 1 means status stuck, 2 means done stuck, 3 means both.
- R3: After the acknowledge, `cfgReqN` goes high. If `statusN` is not seen high within START_US µs, `error` is raised with code 4.
- R4: The first rising edge of `serClk` comes no earlier than SETTLE_US µs after `statusN` rises.
- R5: Every word goes out as 32 bits, bit 0 first. `serClk` idles low, and `serData` changes only while `serClk` is low.
- R6: Each high and low phase of `serClk` lasts at least CLK_HALF clock cycles.
- R7: A word marked `inLast` with `inBytes` from 1 to 3 keeps only that many low bytes; the upper bytes are sent as zeros. No further word follows it.
- R8: A word marked `inLast` with `inBytes` = 0 is sent whole (0 means four bytes), and one all-zero word follows it.
- R9: `inBytes` has no effect on words not marked `inLast`; they are sent whole.
- R10: After the last word, both `statusN` and `cfgDone` seen high within DONE_US µs gives `done`. Otherwise `error` is raised with code {1, cfgDone low, statusN low}: 5 means status low, 6 means done low, 7 means both. `done` and `error` never hold together.
- R11: `inReady` is high only while `busy` is high and the serialiser is idle, with `serClk` low. `busy` falls in the same cycle that `done` or `error` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Single-cycle pulse that begins a load when idle |
| inValid | input | 1 | Bitstream word valid |
| inReady | output | 1 | Block accepts a word this cycle |
| inData | input | 8*WORD_BYTES | Bitstream word |
| inLast | input | 1 | Marks the final word of the load |
| inBytes | input | $clog2(WORD_BYTES) | Valid low bytes of the final word, 0 = all |
| cfgReqN | output | 1 | Active-low configuration request to the target |
| statusN | input | 1 | Active-low status line from the target |
| cfgDone | input | 1 | Configuration-complete line from the target |
| serClk | output | 1 | Serial data clock, idle low |
| serData | output | 1 | Serial data, LSB first |
| busy | output | 1 | A load is in progress |
| done | output | 1 | Last load completed, held until next start |
| error | output | 1 | Last load failed, held until next start |
| errCode | output | 3 | Failure cause, 0 when no error |

## Verification
A control state that stalls or skips a step shows at the ports through `cfgReqN`, `busy` and the cause code. A stalled step ends in the wrong code at a time far from the expected window. A skipped step ends in a reply to the target before the window has run. A serialiser fault, such as a wrong shift direction, a lost bit or a missing or extra pad word, corrupts the very next word collected from `serData`. That word is compared whole against the expected value within 32 serial clocks. A divider fault shows on the first short `serClk` phase.

// File: rtl/pscfg_pkg.sv
package pscfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAITST,
    ST_SETTLE,
    ST_STREAM,
    ST_SHIFT,
    ST_TRAIL,
    ST_CHECK
  } ctrlState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic load;      // start serialising a word this cycle
    logic zeroWord;  // the word to load is all zeros
    logic useTail;   // apply the partial-byte mask to the input word
  } strobe_t;

  localparam logic [2:0] ERR_NONE  = 3'd0;
  localparam logic [2:0] ERR_START = 3'd4;

endpackage

// File: rtl/pscfg_sync.sv
module pscfg_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rstN) pipe <= RST_VAL;
        else       pipe <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rstN) pipe <= {STAGES{RST_VAL}};
        else       pipe <= {pipe[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/pscfg_ctrl.sv
module pscfg_ctrl
  import pscfg_pkg::*;
#(
  parameter int ACK_CYC    = 500,
  parameter int START_CYC  = 400000,
  parameter int SETTLE_CYC = 500,
  parameter int DONE_CYC   = 2500,
  parameter int BYTE_W     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              inValid,
  input  logic              inLast,
  input  logic [BYTE_W-1:0] inBytes,
  input  logic              statHigh,
  input  logic              doneHigh,
  input  logic              wordDone,
  output logic              cfgReqN,
  output logic              inReady,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [2:0]        errCode,
  output strobe_t           stb
);

  localparam int MAX_AB  = (ACK_CYC > START_CYC) ? ACK_CYC : START_CYC;
  localparam int MAX_CD  = (SETTLE_CYC > DONE_CYC) ? SETTLE_CYC : DONE_CYC;
  localparam int MAX_CYC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int TMR_W   = $clog2(MAX_CYC + 1);

  ctrlState_e       state;
  logic [TMR_W-1:0] timer;
  logic             lastSeen;
  logic             padded;
  logic             accept;
  logic             tailPartial;
  logic             trailLoad;

  always_comb begin
    inReady      = (state == ST_STREAM);
    accept       = inReady && inValid;
    tailPartial  = inLast && (inBytes != '0);
    trailLoad    = (state == ST_SHIFT) && wordDone && lastSeen && !padded;
    stb.load     = accept || trailLoad;
    stb.zeroWord = trailLoad;
    stb.useTail  = accept && tailPartial;
    cfgReqN      = (state != ST_REQ);
    busy         = (state != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      timer    <= '0;
      done     <= 1'b0;
      error    <= 1'b0;
      errCode  <= ERR_NONE;
      lastSeen <= 1'b0;
      padded   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_REQ;
            timer   <= '0;
            done    <= 1'b0;
            error   <= 1'b0;
            errCode <= ERR_NONE;
          end
        end
        ST_REQ: begin
          if (!statHigh && !doneHigh) begin
            state <= ST_WAITST;
            timer <= '0;
          end else if (timer == TMR_W'(ACK_CYC - 1)) begin
            state   <= ST_IDLE;
            error   <= 1'b1;
            errCode <= {1'b0, doneHigh, statHigh};
          end else begin
            timer <= timer + 1'b1;
          end
        end
        ST_WAITST: begin
          if (statHigh) begin
            state <= ST_SETTLE;
            timer <= '0;
          end else if (timer == TMR_W'(START_CYC - 1)) begin
            state   <= ST_IDLE;
            error   <= 1'b1;
            errCode <= ERR_START;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        ST_SETTLE: begin
          if (timer == TMR_W'(SETTLE_CYC - 1)) begin
            state    <= ST_STREAM;
            lastSeen <= 1'b0;
            padded   <= 1'b0;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        ST_STREAM: begin
          if (accept) begin
            state    <= ST_SHIFT;
            lastSeen <= inLast;
            padded   <= tailPartial;
          end
        end
        ST_SHIFT: begin
          if (wordDone) begin
            if (!lastSeen) begin
              state <= ST_STREAM;
            end else if (padded) begin
              state <= ST_CHECK;
              timer <= '0;
            end else begin
              state <= ST_TRAIL;
            end
          end
        end
        ST_TRAIL: begin
          if (wordDone) begin
            state <= ST_CHECK;
            timer <= '0;
          end
        end
        ST_CHECK: begin
          if (statHigh && doneHigh) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else if (timer == TMR_W'(DONE_CYC - 1)) begin
            state   <= ST_IDLE;
            error   <= 1'b1;
            errCode <= {1'b1, !doneHigh, !statHigh};
          end else begin
            timer <= timer + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pscfg_shift.sv
module pscfg_shift
  import pscfg_pkg::*;
#(
  parameter int WORD_BYTES = 4,
  parameter int CLK_HALF   = 13,
  parameter int BYTE_W     = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 stb,
  input  logic [8*WORD_BYTES-1:0] inData,
  input  logic [BYTE_W-1:0]       inBytes,
  output logic                    serClk,
  output logic                    serData,
  output logic                    wordDone
);

  localparam int WORD_W = 8 * WORD_BYTES;
  localparam int BIT_W  = $clog2(WORD_W);
  localparam int HC_W   = $clog2(CLK_HALF + 1);

  logic [WORD_W-1:0] loadWord;
  logic [WORD_W-1:0] shreg;
  logic [BIT_W-1:0]  bitCnt;
  logic [HC_W-1:0]   halfCnt;
  logic              phase;
  logic              active;

  // keep only the valid low bytes of a partial final word
  for (genvar b = 0; b < WORD_BYTES; b++) begin : g_mask
    logic keepByte;
    assign keepByte = !stb.useTail || (inBytes > BYTE_W'(b));
    assign loadWord[8*b +: 8] = keepByte ? inData[8*b +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shreg    <= '0;
      bitCnt   <= '0;
      halfCnt  <= '0;
      phase    <= 1'b0;
      active   <= 1'b0;
      wordDone <= 1'b0;
    end else begin
      wordDone <= 1'b0;
      if (stb.load) begin
        shreg   <= stb.zeroWord ? '0 : loadWord;
        bitCnt  <= '0;
        halfCnt <= '0;
        phase   <= 1'b0;
        active  <= 1'b1;
      end else if (active) begin
        if (halfCnt == HC_W'(CLK_HALF - 1)) begin
          halfCnt <= '0;
          if (!phase) begin
            phase <= 1'b1;
          end else begin
            phase <= 1'b0;
            shreg <= {1'b0, shreg[WORD_W-1:1]};
            if (bitCnt == BIT_W'(WORD_W - 1)) begin
              active   <= 1'b0;
              wordDone <= 1'b1;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end else begin
          halfCnt <= halfCnt + 1'b1;
        end
      end
    end
  end

  assign serClk  = phase;
  assign serData = active & shreg[0];

endmodule

// File: rtl/pserial_cfg_master.sv
module pserial_cfg_master
  import pscfg_pkg::*;
#(
  parameter int CLK_PER_US  = 250,
  parameter int ACK_US      = 2,
  parameter int START_US    = 1600,
  parameter int SETTLE_US   = 2,
  parameter int DONE_US     = 10,
  parameter int CLK_HALF    = 13,
  parameter int WORD_BYTES  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          start,
  input  logic                          inValid,
  output logic                          inReady,
  input  logic [8*WORD_BYTES-1:0]       inData,
  input  logic                          inLast,
  input  logic [$clog2(WORD_BYTES)-1:0] inBytes,
  output logic                          cfgReqN,
  input  logic                          statusN,
  input  logic                          cfgDone,
  output logic                          serClk,
  output logic                          serData,
  output logic                          busy,
  output logic                          done,
  output logic                          error,
  output logic [2:0]                    errCode
);

  localparam int BYTE_W     = $clog2(WORD_BYTES);
  localparam int ACK_CYC    = ACK_US * CLK_PER_US;
  localparam int START_CYC  = START_US * CLK_PER_US;
  localparam int SETTLE_CYC = SETTLE_US * CLK_PER_US;
  localparam int DONE_CYC   = DONE_US * CLK_PER_US;

  logic    statHigh;
  logic    doneHigh;
  logic    wordDone;
  strobe_t stb;

  pscfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_syncStat (
    .clk(clk), .rstN(rstN), .din(statusN), .dout(statHigh)
  );

  pscfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_syncDone (
    .clk(clk), .rstN(rstN), .din(cfgDone), .dout(doneHigh)
  );

  pscfg_ctrl #(
    .ACK_CYC(ACK_CYC), .START_CYC(START_CYC), .SETTLE_CYC(SETTLE_CYC),
    .DONE_CYC(DONE_CYC), .BYTE_W(BYTE_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .inValid(inValid),
    .inLast(inLast), .inBytes(inBytes), .statHigh(statHigh),
    .doneHigh(doneHigh), .wordDone(wordDone), .cfgReqN(cfgReqN),
    .inReady(inReady), .busy(busy), .done(done), .error(error),
    .errCode(errCode), .stb(stb)
  );

  pscfg_shift #(
    .WORD_BYTES(WORD_BYTES), .CLK_HALF(CLK_HALF), .BYTE_W(BYTE_W)
  ) u_shift (
    .clk(clk), .rstN(rstN), .stb(stb), .inData(inData), .inBytes(inBytes),
    .serClk(serClk), .serData(serData), .wordDone(wordDone)
  );

endmodule

// File: rtl/pscfg_checker.sv
module pscfg_checker #(
  parameter int CLK_HALF = 13
) (
  input logic       clk,
  input logic       rstN,
  input logic       cfgReqN,
  input logic       inReady,
  input logic       busy,
  input logic       done,
  input logic       error,
  input logic [2:0] errCode,
  input logic       serClk,
  input logic       serData
);

  localparam int L_W = $clog2(CLK_HALF + 2);

  logic           prevClk;
  logic [L_W-1:0] runLen;

  // cycles since serClk last changed, saturating at CLK_HALF
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevClk <= 1'b0;
      runLen  <= L_W'(CLK_HALF);
    end else begin
      prevClk <= serClk;
      if (serClk != prevClk)                 runLen <= '0;
      else if (runLen != L_W'(CLK_HALF))     runLen <= runLen + 1'b1;
    end
  end

  assert_req_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    !cfgReqN |-> busy);

  assert_code_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    !error |-> (errCode == 3'd0));

  assert_idle_clk_R5: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !serClk);

  assert_data_low_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(serData) |-> !serClk);

  assert_half_len_R6: assert property (@(posedge clk) disable iff (!rstN)
    (serClk != prevClk) |-> (runLen >= L_W'(CLK_HALF - 1)));

  assert_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error));

  assert_ready_R11: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> (busy && !serClk));

  assert_end_R11: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(done) || $rose(error)) |-> !busy);

endmodule

bind pserial_cfg_master pscfg_checker #(.CLK_HALF(CLK_HALF)) u_chk (
  .clk(clk), .rstN(rstN), .cfgReqN(cfgReqN), .inReady(inReady),
  .busy(busy), .done(done), .error(error), .errCode(errCode),
  .serClk(serClk), .serData(serData)
);

// File: tb/sim_pserial_cfg_master.sv
`timescale 1ns/1ps
module sim_pserial_cfg_master;

  localparam int CPU    = 4;
  localparam int CH     = 2;
  localparam int ACKC   = 2 * CPU;
  localparam int STARTC = 1600 * CPU;
  localparam int SETC   = 2 * CPU;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] inData = '0;
  logic        inLast = 1'b0;
  logic [1:0]  inBytes = '0;
  logic        cfgReqN;
  logic        statusN = 1'b1;
  logic        cfgDone = 1'b1;
  logic        serClk;
  logic        serData;
  logic        busy;
  logic        done;
  logic        error;
  logic [2:0]  errCode;

  always #2 clk = ~clk;

  pserial_cfg_master #(.CLK_PER_US(CPU), .CLK_HALF(CH)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .inValid(inValid),
    .inReady(inReady), .inData(inData), .inLast(inLast), .inBytes(inBytes),
    .cfgReqN(cfgReqN), .statusN(statusN), .cfgDone(cfgDone),
    .serClk(serClk), .serData(serData), .busy(busy), .done(done),
    .error(error), .errCode(errCode)
  );

  int nChk = 0;
  int nBad = 0;
  int cyc  = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag,
                       input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard: expected serial words
  logic [31:0] expQ[$];

  // monitor: collects bits on rising serClk
  logic        prevSer = 1'b0;
  int          nBits = 0;
  logic [31:0] acc = '0;
  bit          armRise = 0;
  int          firstRise = 0;
  int          highLen = 0;
  int          minHigh = 999;

  always @(negedge clk) begin
    if (serClk && !prevSer) begin
      acc[nBits[4:0]] = serData;
      nBits++;
      highLen = 1;
      if (armRise) begin
        firstRise = cyc;
        armRise = 0;
      end
      if (nBits == 32) begin
        nBits = 0;
        if (expQ.size() == 0) begin
          check(0, "R7/R8 extra word", acc, 0);
        end else begin
          logic [31:0] e;
          e = expQ.pop_front();
          check(acc == e, "R5 word bit order", acc, e);
        end
      end
    end else if (serClk) begin
      highLen++;
    end else if (prevSer) begin
      if (highLen < minHigh) minHigh = highLen;
    end
    prevSer = serClk;
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 150000) begin
      nBad++;
      $display("FAIL watchdog R11 busy=%0d expected=0", busy);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  // one load attempt against a modelled target
  task automatic runLoad(input int seed, input int nWords, input int lastBytes,
                         input int ackDelay, input bit stuckStat, input bit stuckDone,
                         input int startDelay, input bit startNever,
                         input int finMode, input bit oddBytes);
    int t0;
    int tStat;
    int el;
    statusN = 1'b1;
    cfgDone = 1'b1;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(busy == 1'b1, "R11 busy after start", busy, 1);
    check(cfgReqN == 1'b0, "R2 request low", cfgReqN, 0);
    t0 = cyc;
    repeat (ackDelay) @(negedge clk);
    statusN = stuckStat;
    cfgDone = stuckDone;
    if (stuckStat || stuckDone) begin
      waitIdle();
      el = cyc - t0;
      check(error && errCode == {1'b0, stuckDone, stuckStat}, "R2 ack code",
            {error, errCode}, {1'b1, 1'b0, stuckDone, stuckStat});
      check(el >= ACKC && el <= ACKC + 6, "R2 ack window", el, ACKC);
      check(cfgReqN == 1'b1, "R2 request released", cfgReqN, 1);
      return;
    end
    while (!cfgReqN && busy) @(negedge clk);
    check(cfgReqN == 1'b1 && busy, "R3 release after ack", cfgReqN, 1);
    if (startNever) begin
      t0 = cyc;
      waitIdle();
      el = cyc - t0;
      check(error && errCode == 3'd4, "R3 start timeout code", errCode, 4);
      check(el >= STARTC - 4 && el <= STARTC + 8, "R3 start window", el, STARTC);
      return;
    end
    repeat (startDelay) @(negedge clk);
    statusN = 1'b1;
    tStat = cyc;
    armRise = 1;
    minHigh = 999;
    for (int i = 0; i < nWords; i++) begin
      logic [31:0] w;
      logic [31:0] m;
      bit last;
      last = (i == nWords - 1);
      w = 32'h8D30_17C5 ^ (seed * 32'h0101_0101) ^ (i * 32'h00F0_1E3B);
      m = (lastBytes == 0) ? 32'hFFFF_FFFF : ((32'h1 << (8 * lastBytes)) - 1);
      inValid = 1'b1;
      inData  = w;
      inLast  = last;
      inBytes = last ? 2'(lastBytes) : (oddBytes ? 2'd1 : 2'd0);
      // R7 masks the tail, R9 ignores inBytes on earlier words
      expQ.push_back(last ? (w & m) : w);
      if (last && lastBytes == 0) expQ.push_back(32'h0); // R8 trailing word
      while (!inReady) @(negedge clk);
      @(negedge clk);
    end
    inValid = 1'b0;
    inLast  = 1'b0;
    while (expQ.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
    case (finMode)
      0: cfgDone = 1'b1;
      2: statusN = 1'b0;
      default: ;
    endcase
    waitIdle();
    check(firstRise - tStat >= SETC, "R4 settle gap", firstRise - tStat, SETC);
    check(minHigh >= CH, "R6 clock high phase", minHigh, CH);
    check(nBits == 0, "R7/R8 no partial word", nBits, 0);
    if (finMode == 0) begin
      check(done && !error && errCode == 3'd0, "R10 success", {done, error, errCode}, 5'b10000);
    end else begin
      logic [2:0] ec;
      ec = (finMode == 1) ? 3'd6 : 3'd7;
      check(error && !done && errCode == ec, "R10 failure code", errCode, ec);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(cfgReqN == 1 && !serClk && !serData && !busy && !done && !error && !inReady,
          "R1 during reset", {cfgReqN, serClk, serData, busy, done, error, inReady}, 7'b1000000);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(cfgReqN == 1 && !serClk && !serData && !busy && !done && !error && !inReady,
          "R1 after reset", {cfgReqN, serClk, serData, busy, done, error, inReady}, 7'b1000000);

    runLoad(1, 3, 0, 3, 0, 0, 20, 0, 0, 1);     // R8, R9
    runLoad(2, 2, 1, 0, 0, 0, 20, 0, 0, 0);     // R7 one byte
    runLoad(3, 4, 3, 2, 0, 0, 10, 0, 0, 0);     // R7 three bytes
    runLoad(4, 1, 0, 0, 1, 0, 0, 0, 0, 0);      // R2 status stuck
    runLoad(5, 1, 0, 0, 0, 1, 0, 0, 0, 0);      // R2 done stuck
    runLoad(6, 1, 0, 1, 0, 0, 0, 1, 0, 0);      // R3 start timeout
    runLoad(7, 1, 2, 1, 0, 0, 1506 * CPU, 0, 0, 0); // R3 late but valid
    runLoad(8, 2, 0, 1, 0, 0, 15, 0, 1, 0);     // R10 done low
    runLoad(9, 1, 3, 1, 0, 0, 15, 0, 2, 0);     // R10 both low
    check(expQ.size() == 0, "R5 all words seen", expQ.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule